// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block converts a single pulse-width request into the two switch enables of a synchronous half bridge. Neither switch is enabled on a timer. Each waits until a sense flag reports that the opposite gate has really discharged, so the dead time follows the actual gate behaviour. The upper switch is then held off for a minimum interval after each turn-off. That interval leaves time to recharge the bootstrap supply and to sample the overcurrent comparator on the lower switch.

With forced-continuous mode off, the lower switch behaves like a diode. A zero-cross flag ends its conduction, and it stays off until the next falling edge of the request. With forced-continuous mode on, the lower switch conducts for the whole off period. Two conditions force both switches off and raise a tri-state indication. One is a fault tri-state request. The other is a dead-time watchdog, which fires when the awaited gate-off flag has not arrived within a programmable number of cycles.

Top module: `hb_gate_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `hi_en`, `lo_en`, `tri_out`, `oc_strobe` and `oc_trip` are all low.
- R2: After `pwm_req` rises, `hi_en` goes high only in the cycle after an edge at which `lo_gate_off` = 1 is sampled. From idle, with the flag already set and the minimum off time expired, `hi_en` is high two cycles after `pwm_req` is set.
- R3: After `pwm_req` falls, `lo_en` goes high only in the cycle after an edge at which `hi_gate_off` = 1 is sampled. Until then both enables are low.
- R4: `hi_en` and `lo_en` are never high in the same cycle.
- R5: With `fccm_sel` = 0, `zc_flag` = 1 during lower conduction, once the minimum off time has expired, drops `lo_en` at the next edge. It then stays low while `pwm_req` is low, even after `zc_flag` clears.
- R6: With `fccm_sel` = 1, `zc_flag` has no effect: `lo_en` stays high until `pwm_req` rises.
- R7: Once `hi_en` falls, it stays low for at least MIN_OFF cycles. If the request comes back at once, it returns after exactly MIN_OFF low cycles.
- R8: A zero-cross seen while the minimum off window is still running does not end lower conduction.
- R9: `oc_strobe` pulses for one cycle, OC_DLY cycles after `lo_en` rises, and only while `lo_en` is high. In the following cycle, `oc_trip` equals `oc_cmp` as sampled at the strobe.
- R10: `tri_req` = 1 forces `hi_en` = `lo_en` = 0 and `tri_out` = 1 from the next cycle on. After release, the block idles with both switches off until the next request edge.
- R11: If the awaited gate-off flag stays low for `dt_timeout` consecutive wait cycles, both enables are forced low and `tri_out` = 1. This holds, even if the flag arrives late, until `pwm_req` differs from its level at the trip. `dt_timeout` = 0 disables the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_req | input | 1 | Pulse-width request: 1 asks for upper conduction |
| lo_gate_off | input | 1 | Lower gate sensed below its off threshold |
| hi_gate_off | input | 1 | Upper gate-to-phase voltage sensed below its off threshold |
| zc_flag | input | 1 | Inductor current about to reverse |
| fccm_sel | input | 1 | 1 = forced continuous, 0 = diode emulation |
| tri_req | input | 1 | Fault request to turn both switches off |
| oc_cmp | input | 1 | Overcurrent comparator output |
| dt_timeout | input | DT_W | Dead-time watchdog limit in cycles, 0 = off |
| hi_en | output | 1 | Upper switch enable |
| lo_en | output | 1 | Lower switch enable |
| tri_out | output | 1 | Both switches held off by fault or watchdog |
| oc_strobe | output | 1 | Overcurrent sample instant |
| oc_trip | output | 1 | Comparator value captured at the strobe |

## Verification
A sequencer stuck in a wait state shows at the ports as a missing enable. This happens one or two cycles after the matching sense flag arrives, or as a watchdog trip exactly `dt_timeout` cycles after the wait began. A wrong minimum-off count shifts the upper re-enable by a measurable number of cycles, and a wrong lower-interval age moves the strobe off its OC_DLY slot. A diode-emulation state that fails to latch shows as `lo_en` rising again while the request is still low, within one cycle of `zc_flag` clearing.

// File: rtl/hbgs_pkg.sv
package hbgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_HI = 3'd1,
    ST_HI_ON   = 3'd2,
    ST_WAIT_LO = 3'd3,
    ST_LO_ON   = 3'd4,
    ST_FAULT   = 3'd5,
    ST_TRIP    = 3'd6
  } seq_state_t;
endpackage

// File: rtl/hbgs_fsm.sv
module hbgs_fsm
  import hbgs_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_req,
  input  logic            lo_gate_off,
  input  logic            hi_gate_off,
  input  logic            zc_flag,
  input  logic            fccm_sel,
  input  logic            tri_req,
  input  logic [DT_W-1:0] dt_timeout,
  input  logic            off_ok,
  output seq_state_t      state,
  output logic            hi_drop
);
  seq_state_t      st_q, st_d;
  logic [DT_W-1:0] wd_q, wd_d;
  logic            lvl_q, lvl_d;
  logic            waiting, opp_off, wd_hit;
  logic [DT_W:0]   wd_inc;

  // Watchdog: consecutive wait cycles without the opposite-gate-off flag
  assign waiting = (st_q == ST_WAIT_HI) || (st_q == ST_WAIT_LO);
  assign opp_off = (st_q == ST_WAIT_HI) ? lo_gate_off : hi_gate_off;
  assign wd_inc  = {1'b0, wd_q} + (DT_W+1)'(1);
  assign wd_hit  = (dt_timeout != '0) && (wd_inc >= {1'b0, dt_timeout});

  always_comb begin
    st_d  = st_q;
    lvl_d = lvl_q;
    if (tri_req) begin
      st_d = ST_FAULT;
    end else begin
      case (st_q)
        ST_IDLE:    if (pwm_req) st_d = ST_WAIT_HI;
        ST_WAIT_HI: begin
          if (!pwm_req)                    st_d = ST_IDLE;
          else if (lo_gate_off && off_ok)  st_d = ST_HI_ON;
          else if (!lo_gate_off && wd_hit) st_d = ST_TRIP;
        end
        ST_HI_ON:   if (!pwm_req) st_d = ST_WAIT_LO;
        ST_WAIT_LO: begin
          if (pwm_req)          st_d = ST_WAIT_HI;
          else if (hi_gate_off) st_d = ST_LO_ON;
          else if (wd_hit)      st_d = ST_TRIP;
        end
        ST_LO_ON: begin
          if (pwm_req)                             st_d = ST_WAIT_HI;
          else if (!fccm_sel && zc_flag && off_ok) st_d = ST_IDLE;
        end
        ST_FAULT:   st_d = ST_IDLE;
        ST_TRIP:    if (pwm_req != lvl_q) st_d = ST_IDLE;
        default:    st_d = ST_IDLE;
      endcase
    end
    if ((st_d == ST_TRIP) && (st_q != ST_TRIP)) lvl_d = pwm_req;
  end

  always_comb begin
    if ((st_d != st_q) || !waiting || opp_off) wd_d = '0;
    else if (&wd_q)                            wd_d = wd_q;
    else                                       wd_d = wd_q + DT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      wd_q  <= '0;
      lvl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      wd_q  <= wd_d;
      lvl_q <= lvl_d;
    end
  end

  assign state   = st_q;
  assign hi_drop = (st_q == ST_HI_ON) && (st_d != ST_HI_ON);
endmodule

// File: rtl/hbgs_offtimer.sv
module hbgs_offtimer #(
  parameter int MIN_OFF = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_drop,
  output logic off_ok
);
  localparam int CNT_W = $clog2(MIN_OFF + 1);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (hi_drop)            cnt_d = CNT_W'(MIN_OFF - 1);
    else if (cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign off_ok = (cnt_q == '0);
endmodule

// File: rtl/hbgs_ocsample.sv
module hbgs_ocsample #(
  parameter int OC_DLY = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_on,
  input  logic oc_cmp,
  output logic strobe,
  output logic trip
);
  localparam int AGE_W = $clog2(OC_DLY + 2);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(OC_DLY + 1);
  logic [AGE_W-1:0] age_q, age_d;
  logic             trip_q, trip_d;

  assign strobe = lo_on && (age_q == AGE_W'(OC_DLY));

  always_comb begin
    if (!lo_on)               age_d = '0;
    else if (age_q != AGE_MAX) age_d = age_q + AGE_W'(1);
    else                      age_d = age_q;
    trip_d = strobe && oc_cmp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      age_q  <= age_d;
      trip_q <= trip_d;
    end
  end

  assign trip = trip_q;
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hbgs_pkg::*;
#(
  parameter int MIN_OFF = 50,
  parameter int OC_DLY  = 27,
  parameter int DT_W    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_req,
  input  logic            lo_gate_off,
  input  logic            hi_gate_off,
  input  logic            zc_flag,
  input  logic            fccm_sel,
  input  logic            tri_req,
  input  logic            oc_cmp,
  input  logic [DT_W-1:0] dt_timeout,
  output logic            hi_en,
  output logic            lo_en,
  output logic            tri_out,
  output logic            oc_strobe,
  output logic            oc_trip
);
  seq_state_t state;
  logic       hi_drop, off_ok;

  hbgs_fsm #(.DT_W(DT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .lo_gate_off(lo_gate_off),
    .hi_gate_off(hi_gate_off), .zc_flag(zc_flag), .fccm_sel(fccm_sel),
    .tri_req(tri_req), .dt_timeout(dt_timeout), .off_ok(off_ok),
    .state(state), .hi_drop(hi_drop)
  );

  hbgs_offtimer #(.MIN_OFF(MIN_OFF)) u_off (
    .clk(clk), .rst_n(rst_n), .hi_drop(hi_drop), .off_ok(off_ok)
  );

  hbgs_ocsample #(.OC_DLY(OC_DLY)) u_oc (
    .clk(clk), .rst_n(rst_n), .lo_on(lo_en), .oc_cmp(oc_cmp),
    .strobe(oc_strobe), .trip(oc_trip)
  );

  assign hi_en   = (state == ST_HI_ON);
  assign lo_en   = (state == ST_LO_ON);
  assign tri_out = (state == ST_FAULT) || (state == ST_TRIP);
endmodule

// File: rtl/hbgs_checker.sv
module hbgs_checker #(
  parameter int MIN_OFF = 50
) (
  input logic clk,
  input logic rst_n,
  input logic pwm_req,
  input logic lo_gate_off,
  input logic hi_gate_off,
  input logic fccm_sel,
  input logic tri_req,
  input logic oc_cmp,
  input logic hi_en,
  input logic lo_en,
  input logic tri_out,
  input logic oc_strobe,
  input logic oc_trip
);
  localparam int GW = $clog2(MIN_OFF + 1) + 1;
  logic [GW-1:0] gap_q;

  // cycles the upper enable has been observed low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gap_q <= GW'(MIN_OFF);
    else if (hi_en)                gap_q <= '0;
    else if (gap_q < GW'(MIN_OFF)) gap_q <= gap_q + GW'(1);
  end

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_en && lo_en));

  assert_hi_after_looff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_en) |-> ($past(lo_gate_off) && $past(pwm_req)));

  assert_lo_after_hioff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_en) |-> ($past(hi_gate_off) && !$past(pwm_req)));

  assert_min_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_en) |-> (gap_q >= GW'(MIN_OFF)));

  assert_tri_forces_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tri_req |=> (!hi_en && !lo_en && tri_out));

  assert_strobe_in_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oc_strobe |-> lo_en);

  assert_trip_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oc_strobe |=> (oc_trip == $past(oc_cmp)));

  assert_fccm_keeps_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_en && fccm_sel && !pwm_req && !tri_req) |=> lo_en);
endmodule

bind hb_gate_seq hbgs_checker #(.MIN_OFF(MIN_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .lo_gate_off(lo_gate_off),
  .hi_gate_off(hi_gate_off), .fccm_sel(fccm_sel), .tri_req(tri_req),
  .oc_cmp(oc_cmp), .hi_en(hi_en), .lo_en(lo_en), .tri_out(tri_out),
  .oc_strobe(oc_strobe), .oc_trip(oc_trip)
);

// File: tb/hb_gate_seq_tb.sv
module hb_gate_seq_tb;
  localparam int MIN_OFF = 8;
  localparam int OC_DLY  = 3;
  localparam int DT_W    = 8;
  // observed vector {hi_en, lo_en, tri_out, oc_strobe, oc_trip}
  localparam logic [4:0] M_HI  = 5'b10000;
  localparam logic [4:0] M_LO  = 5'b01000;
  localparam logic [4:0] M_TRI = 5'b00100;
  localparam logic [4:0] M_STB = 5'b00010;
  localparam logic [4:0] M_TRP = 5'b00001;
  localparam logic [4:0] M_ALL = 5'b11111;

  logic clk = 1'b0;
  logic rst_n, pwm_req, lo_gate_off, hi_gate_off, zc_flag, fccm_sel, tri_req, oc_cmp;
  logic [DT_W-1:0] dt_timeout;
  logic hi_en, lo_en, tri_out, oc_strobe, oc_trip;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    int         cyc;
    logic [4:0] mask;
    logic [4:0] val;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hb_gate_seq #(.MIN_OFF(MIN_OFF), .OC_DLY(OC_DLY), .DT_W(DT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .lo_gate_off(lo_gate_off),
    .hi_gate_off(hi_gate_off), .zc_flag(zc_flag), .fccm_sel(fccm_sel),
    .tri_req(tri_req), .oc_cmp(oc_cmp), .dt_timeout(dt_timeout),
    .hi_en(hi_en), .lo_en(lo_en), .tri_out(tri_out),
    .oc_strobe(oc_strobe), .oc_trip(oc_trip)
  );

  // monitor: pops expectations due this cycle and compares
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t it;
      logic [4:0] obs;
      it  = q.pop_front();
      obs = {hi_en, lo_en, tri_out, oc_strobe, oc_trip};
      tests++;
      if (it.cyc < cyc) begin
        fails++;
        $display("FAIL %s: check missed at cyc %0d (actual n/a, expected %b)", it.tag, it.cyc, it.val);
      end else if ((obs & it.mask) != (it.val & it.mask)) begin
        fails++;
        $display("FAIL %s: cyc %0d actual=%b expected=%b mask=%b", it.tag, cyc, obs, it.val, it.mask);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input int d, input logic [4:0] mask, input logic [4:0] val, input string tag);
    exp_t it;
    it.cyc = cyc + d; it.mask = mask; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwm_req = 1'b0; lo_gate_off = 1'b1; hi_gate_off = 1'b1;
    zc_flag = 1'b0; fccm_sel = 1'b0; tri_req = 1'b0; oc_cmp = 1'b0;
    dt_timeout = DT_W'(5);
    tick(2);
    expect_at(1, M_ALL, 5'b00000, "R1 outputs low in reset");
    tick(2);
    rst_n = 1'b1;
    expect_at(1, M_ALL, 5'b00000, "R1 idle after reset");
    tick(3);

    // R2: upper waits for lower gate sensed off
    pwm_req = 1'b1; lo_gate_off = 1'b0;
    expect_at(1, M_HI | M_LO, 5'b00000, "R2 upper held while lower not off");
    expect_at(3, M_HI, 5'b00000, "R2 upper still held");
    tick(3);
    lo_gate_off = 1'b1;
    expect_at(1, M_HI | M_LO, 5'b10000, "R2 upper on after lower off");
    tick(3);

    // R3/R9/R8/R5: lower waits for upper gate, strobe, diode emulation
    pwm_req = 1'b0; hi_gate_off = 1'b0;
    expect_at(1, M_HI | M_LO, 5'b00000, "R3 both off in dead time");
    expect_at(2, M_LO, 5'b00000, "R3 lower waits upper sensed off");
    tick(2);
    hi_gate_off = 1'b1; lo_gate_off = 1'b0; oc_cmp = 1'b1;
    expect_at(1, M_LO | M_HI, 5'b01000, "R3 lower on after upper off");
    expect_at(3, M_STB, 5'b00000, "R9 no strobe before delay");
    expect_at(4, M_STB | M_LO, 5'b01010, "R9 strobe after delay");
    expect_at(5, M_STB | M_TRP, 5'b00001, "R9 trip captured");
    tick(2);
    zc_flag = 1'b1;
    expect_at(4, M_LO, 5'b01000, "R8 zero-cross ignored in min off window");
    expect_at(5, M_LO, 5'b00000, "R5 zero-cross turns lower off");
    tick(5);
    zc_flag = 1'b0; oc_cmp = 1'b0;
    expect_at(3, M_LO | M_HI, 5'b00000, "R5 lower stays off until next fall");
    tick(3);

    // R6: forced continuous ignores zero-cross
    pwm_req = 1'b1; lo_gate_off = 1'b1; fccm_sel = 1'b1;
    expect_at(2, M_HI, 5'b10000, "R2 upper on from idle in two cycles");
    tick(3);
    pwm_req = 1'b0; hi_gate_off = 1'b1; lo_gate_off = 1'b0;
    expect_at(1, M_LO | M_HI, 5'b00000, "R3 dead time before lower");
    expect_at(2, M_LO, 5'b01000, "R3 lower on in forced mode");
    tick(2);
    zc_flag = 1'b1;
    expect_at(7, M_LO, 5'b01000, "R6 zero-cross ignored after window");
    expect_at(10, M_LO, 5'b01000, "R6 lower conducts whole off period");
    tick(10);

    // R11: watchdog trip waiting for lower gate off
    pwm_req = 1'b1; zc_flag = 1'b0; fccm_sel = 1'b0;
    expect_at(5, M_ALL, 5'b00000, "R11 no trip before limit");
    expect_at(6, M_ALL, 5'b00100, "R11 trip at limit");
    tick(6);
    lo_gate_off = 1'b1;
    expect_at(2, M_HI | M_TRI, 5'b00100, "R11 trip held on late flag");
    tick(2);
    pwm_req = 1'b0;
    expect_at(1, M_ALL, 5'b00000, "R11 trip cleared by request change");
    tick(1);
    dt_timeout = '0; pwm_req = 1'b1; lo_gate_off = 1'b0;
    expect_at(25, M_HI | M_TRI, 5'b00000, "R11 zero limit disables watchdog");
    tick(25);
    lo_gate_off = 1'b1;
    expect_at(1, M_HI, 5'b10000, "R2 upper on after long wait");
    tick(3);

    // R7: minimum off time on fast re-request
    pwm_req = 1'b0; hi_gate_off = 1'b1;
    expect_at(1, M_HI | M_LO, 5'b00000, "R7 upper off");
    tick(1);
    pwm_req = 1'b1;
    expect_at(7, M_HI, 5'b00000, "R7 upper held in min off");
    expect_at(8, M_HI | M_LO, 5'b10000, "R7 upper back after min off");
    tick(9);

    // R10: tri-state request
    tri_req = 1'b1;
    expect_at(1, M_HI | M_LO | M_TRI, 5'b00100, "R10 tri forces both off");
    expect_at(3, M_HI | M_LO | M_TRI, 5'b00100, "R10 tri held");
    tick(3);
    tri_req = 1'b0; pwm_req = 1'b0;
    expect_at(1, M_HI | M_LO | M_TRI, 5'b00000, "R10 release to idle");
    expect_at(4, M_LO, 5'b00000, "R10 lower waits for next fall");
    tick(6);

    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule